// File: doc/BRIEF.md
# In-Order Retirement Controller

This block sits at the head of a reorder buffer and decides, once per clock, which of the oldest in-flight entries leave it. It sees a window of the `COMMIT_W` oldest entries. It retires completed entries in program order and drops entries that were already cancelled. It also handles the entries that need special treatment at the head: serialising operations, faults and external interrupts.

Serialising operations are released for execution only when they are alone at the head and the store buffer has drained. Faults and accepted interrupts start a trap. The trap freezes retirement for a programmable number of cycles and then sends one flush request, which cancels everything still in flight. The block keeps the architectural program counter. For every cycle that retires something, it reports the sequence number of the youngest retired entry.

The reorder buffer removes `pop_cnt` entries from its head at each clock edge. When `rel_vld` is high, it clears the ready flag of the released entry until that entry completes. When `sq_vld` is high, it flushes every entry younger than `sq_seq`.

Top module: `rob_commit_ctrl`

## Requirements
- R1: Each cycle, the window slots are examined from slot 0 upward. Every valid, ready, executed, fault-free entry is retired, up to `COMMIT_W` retirements. The scan stops at the first slot that is invalid, not ready, or ready but not executed. `cmt_cnt` is the number retired, from 0 to `COMMIT_W`.
- R2: A head-side entry flagged squashed is removed without taking a retirement slot. `pop_cnt` counts removed squashed entries plus retired entries.
- R3: A ready, unexecuted entry flagged serialising raises `rel_vld`, with `rel_seq` set to its sequence number. This happens only when nothing has been retired before it in the same cycle and `st_pend` is low. In every case the scan stops at that entry.
- R4: A ready, executed entry flagged faulting starts a trap only when nothing has been retired before it in the same cycle and `st_pend` is low. In that cycle `trap_fault` pulses, which marks the entry completed, and nothing further is removed. Otherwise the scan stops at that entry without trapping.
- R5: After a trap is taken, nothing is retired, removed or released until the flush. `sq_vld` is high exactly `trap_dly + 1` cycles after the cycle in which the trap was taken. For a fault, `sq_seq` is the faulting entry's sequence number minus one.
- R6: The cycle after `sq_vld`, the controller is running again and retires normally.
- R7: `irq_req` is accepted only when all of the following hold: slot 0 is invalid (the buffer is empty), `st_pend` is low, and no trap is pending. Acceptance pulses `irq_ack`, starts a trap with the same delay rule, and flushes with `sq_seq` equal to 0.
- R8: Reset sets `arch_pc` to `RESET_PC` and `arch_npc` to `RESET_PC+4`. After a cycle that retires n > 0 entries, `arch_npc` has grown by 4n and `arch_pc` equals the new `arch_npc` minus 4. Otherwise both hold.
- R9: `done_vld` is high exactly when `cmt_cnt` is non-zero. `done_seq` then carries the sequence number of the youngest entry retired in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hd_vld | input | COMMIT_W | Slot holds an in-flight entry (bit i = slot i, slot 0 oldest) |
| hd_rdy | input | COMMIT_W | Entry may retire |
| hd_exe | input | COMMIT_W | Entry has executed |
| hd_sqd | input | COMMIT_W | Entry was cancelled |
| hd_flt | input | COMMIT_W | Entry carries a fault |
| hd_ser | input | COMMIT_W | Entry must execute at the head (serialising, barrier, fault-free store-conditional) |
| hd_seq | input | COMMIT_W*SEQ_W | Sequence numbers, slot i in bits [i*SEQ_W +: SEQ_W] |
| st_pend | input | 1 | Store buffer still holds stores to write back |
| irq_req | input | 1 | Interrupt request |
| trap_dly | input | DLY_W | Cycles between a trap and its flush, minus one |
| pop_cnt | output | $clog2(COMMIT_W+1) | Entries to remove from the head this edge |
| cmt_cnt | output | $clog2(COMMIT_W+1) | Entries retired this cycle |
| done_vld | output | 1 | At least one entry retired |
| done_seq | output | SEQ_W | Youngest retired sequence number |
| rel_vld | output | 1 | Release the stopped entry for execution |
| rel_seq | output | SEQ_W | Sequence number of the released entry |
| trap_fault | output | 1 | Fault trap taken; faulting entry completed |
| irq_ack | output | 1 | Interrupt accepted |
| sq_vld | output | 1 | Flush everything younger than `sq_seq` |
| sq_seq | output | SEQ_W | Flush boundary |
| arch_pc | output | PC_W | Architectural program counter |
| arch_npc | output | PC_W | Architectural next program counter |

## Verification
The hardest state to reach is the trap-pending window. During it the head window may show fully retirable entries, yet nothing may leave. The bench takes a fault trap with a non-zero delay and then presents an all-ready window on every following cycle. It checks that nothing is retired until the flush pulse arrives in exactly the cycle the delay predicts, and that retirement resumes one cycle later. The interrupt path needs an empty buffer and a drained store buffer together, so the bench first holds the request with stores outstanding before draining them.

// File: rtl/rcc_pkg.sv
`timescale 1ns/1ps
// Shared types for the retirement controller.
// Assumes: nothing beyond IEEE 1800-2017.
package rcc_pkg;
    typedef enum logic {
        RCC_RUN  = 1'b0,
        RCC_PEND = 1'b1
    } rcc_state_t;
endpackage

// File: rtl/rcc_scan.sv
`timescale 1ns/1ps
// Head-window scanner: walks the oldest COMMIT_W entries in order and decides
// removals, retirements, a release, or a fault trap for this cycle.
// Assumes: slot 0 is the oldest entry; en low forces all decisions to zero.
module rcc_scan #(
    parameter int COMMIT_W = 4,
    parameter int SEQ_W    = 16,
    localparam int CW      = $clog2(COMMIT_W + 1)
) (
    input  logic                      en,
    input  logic                      st_pend,
    input  logic [COMMIT_W-1:0]       vld,
    input  logic [COMMIT_W-1:0]       rdy,
    input  logic [COMMIT_W-1:0]       exe,
    input  logic [COMMIT_W-1:0]       sqd,
    input  logic [COMMIT_W-1:0]       flt,
    input  logic [COMMIT_W-1:0]       ser,
    input  logic [COMMIT_W*SEQ_W-1:0] seq,
    output logic [CW-1:0]             pop,
    output logic [CW-1:0]             used,
    output logic [SEQ_W-1:0]          last_seq,
    output logic                      rel,
    output logic                      take_flt,
    output logic [SEQ_W-1:0]          stop_seq
);
    logic [SEQ_W-1:0] slot_seq [COMMIT_W];

    // Split the flat sequence bus into one number per slot.
    for (genvar g = 0; g < COMMIT_W; g++) begin : g_slot
        assign slot_seq[g] = seq[g*SEQ_W +: SEQ_W];
    end

    // In-order walk of the window; the first blocking entry ends the scan.
    always_comb begin
        logic stop;
        stop     = !en;
        pop      = '0;
        used     = '0;
        last_seq = '0;
        rel      = 1'b0;
        take_flt = 1'b0;
        stop_seq = '0;
        for (int i = 0; i < COMMIT_W; i++) begin
            if (!stop) begin
                if (!vld[i]) begin
                    stop = 1'b1;
                end else if (sqd[i]) begin
                    pop = pop + 1'b1;
                end else if (used == CW'(COMMIT_W)) begin
                    stop = 1'b1;
                end else if (!rdy[i]) begin
                    stop = 1'b1;
                end else if (!exe[i]) begin
                    stop     = 1'b1;
                    stop_seq = slot_seq[i];
                    rel      = ser[i] && (used == '0) && !st_pend;
                end else if (flt[i]) begin
                    stop     = 1'b1;
                    stop_seq = slot_seq[i];
                    take_flt = (used == '0) && !st_pend;
                end else begin
                    used     = used + 1'b1;
                    pop      = pop + 1'b1;
                    last_seq = slot_seq[i];
                end
            end
        end
    end
endmodule

// File: rtl/rcc_pc.sv
`timescale 1ns/1ps
// Architectural PC pair: advances by the fixed 4-byte instruction size per
// retired entry.
// Assumes: cnt never exceeds the retirement width.
module rcc_pc #(
    parameter int          PC_W     = 32,
    parameter int          CW       = 3,
    parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   cnt,
    output logic [PC_W-1:0] pc,
    output logic [PC_W-1:0] npc
);
    logic [PC_W-1:0] step;
    logic [PC_W-1:0] npc_next;

    // Byte distance covered by this cycle's retirements.
    assign step     = PC_W'(cnt) << 2;
    assign npc_next = npc + step;

    // PC register update on any retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc  <= PC_W'(RESET_PC);
            npc <= PC_W'(RESET_PC) + PC_W'(4);
        end else if (cnt != '0) begin
            pc  <= npc_next - PC_W'(4);
            npc <= npc_next;
        end
    end
endmodule

// File: rtl/rcc_trap.sv
`timescale 1ns/1ps
// Trap sequencer: holds the controller in a pending state for a programmed
// delay, then issues one flush pulse and resumes.
// Assumes: take is only raised while run is high.
module rcc_trap #(
    parameter int DLY_W = 4,
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [DLY_W-1:0] dly,
    input  logic [SEQ_W-1:0] seq_in,
    output logic             run,
    output logic             sq_vld,
    output logic [SEQ_W-1:0] sq_seq
);
    import rcc_pkg::*;

    rcc_state_t       st_q;
    logic [DLY_W-1:0] cnt_q;
    logic [SEQ_W-1:0] seq_q;

    // State, delay countdown and captured flush boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= RCC_RUN;
            cnt_q <= '0;
            seq_q <= '0;
        end else if (st_q == RCC_RUN) begin
            if (take) begin
                st_q  <= RCC_PEND;
                cnt_q <= dly;
                seq_q <= seq_in;
            end
        end else if (cnt_q == '0) begin
            st_q <= RCC_RUN;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign run    = (st_q == RCC_RUN);
    assign sq_vld = (st_q == RCC_PEND) && (cnt_q == '0);
    assign sq_seq = seq_q;
endmodule

// File: rtl/rob_commit_ctrl.sv
`timescale 1ns/1ps
// In-order retirement controller for the head of a reorder buffer.
// Combines the window scanner, the trap sequencer and the PC pair; takes
// interrupts only when the buffer and the store buffer are empty.
// Assumes: window inputs describe the buffer state before this edge's pop.
module rob_commit_ctrl #(
    parameter int          COMMIT_W = 4,
    parameter int          SEQ_W    = 16,
    parameter int          PC_W     = 32,
    parameter int          DLY_W    = 4,
    parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [COMMIT_W-1:0]              hd_vld,
    input  logic [COMMIT_W-1:0]              hd_rdy,
    input  logic [COMMIT_W-1:0]              hd_exe,
    input  logic [COMMIT_W-1:0]              hd_sqd,
    input  logic [COMMIT_W-1:0]              hd_flt,
    input  logic [COMMIT_W-1:0]              hd_ser,
    input  logic [COMMIT_W*SEQ_W-1:0]        hd_seq,
    input  logic                             st_pend,
    input  logic                             irq_req,
    input  logic [DLY_W-1:0]                 trap_dly,
    output logic [$clog2(COMMIT_W+1)-1:0]    pop_cnt,
    output logic [$clog2(COMMIT_W+1)-1:0]    cmt_cnt,
    output logic                             done_vld,
    output logic [SEQ_W-1:0]                 done_seq,
    output logic                             rel_vld,
    output logic [SEQ_W-1:0]                 rel_seq,
    output logic                             trap_fault,
    output logic                             irq_ack,
    output logic                             sq_vld,
    output logic [SEQ_W-1:0]                 sq_seq,
    output logic [PC_W-1:0]                  arch_pc,
    output logic [PC_W-1:0]                  arch_npc
);
    localparam int CW = $clog2(COMMIT_W + 1);

    logic             run;
    logic             take_flt;
    logic [SEQ_W-1:0] stop_seq;
    logic [SEQ_W-1:0] trap_seq;
    logic [CW-1:0]    used;

    // Interrupt acceptance: empty buffer, drained stores, nothing pending.
    assign irq_ack = run && irq_req && !hd_vld[0] && !st_pend;

    rcc_scan #(.COMMIT_W(COMMIT_W), .SEQ_W(SEQ_W)) scan_i (
        .en       (run),
        .st_pend  (st_pend),
        .vld      (hd_vld),
        .rdy      (hd_rdy),
        .exe      (hd_exe),
        .sqd      (hd_sqd),
        .flt      (hd_flt),
        .ser      (hd_ser),
        .seq      (hd_seq),
        .pop      (pop_cnt),
        .used     (used),
        .last_seq (done_seq),
        .rel      (rel_vld),
        .take_flt (take_flt),
        .stop_seq (stop_seq)
    );

    // Flush boundary: one below the faulting entry, or zero for an interrupt.
    assign trap_seq   = take_flt ? stop_seq - 1'b1 : '0;
    assign trap_fault = take_flt;
    assign rel_seq    = stop_seq;
    assign cmt_cnt    = used;
    assign done_vld   = (used != '0);

    rcc_trap #(.DLY_W(DLY_W), .SEQ_W(SEQ_W)) trap_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take_flt || irq_ack),
        .dly    (trap_dly),
        .seq_in (trap_seq),
        .run    (run),
        .sq_vld (sq_vld),
        .sq_seq (sq_seq)
    );

    rcc_pc #(.PC_W(PC_W), .CW(CW), .RESET_PC(RESET_PC)) pc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (used),
        .pc    (arch_pc),
        .npc   (arch_npc)
    );
endmodule

// File: rtl/rob_commit_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for the retirement controller, bound to every instance.
// Assumes: default parameter relations of the top module.
module rob_commit_ctrl_chk #(
    parameter int COMMIT_W = 4,
    parameter int PC_W     = 32,
    localparam int CW      = $clog2(COMMIT_W + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [COMMIT_W-1:0] hd_vld,
    input logic                st_pend,
    input logic [CW-1:0]       pop_cnt,
    input logic [CW-1:0]       cmt_cnt,
    input logic                done_vld,
    input logic                rel_vld,
    input logic                trap_fault,
    input logic                irq_ack,
    input logic                sq_vld,
    input logic [PC_W-1:0]     arch_pc,
    input logic [PC_W-1:0]     arch_npc
);
    // R1
    width_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_cnt <= CW'(COMMIT_W) && cmt_cnt <= pop_cnt);

    // R3
    release_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_vld |-> !st_pend && cmt_cnt == '0);

    // R4
    fault_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_fault |-> !st_pend && cmt_cnt == '0);

    // R5
    pending_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_fault || irq_ack) |=> pop_cnt == '0 && !rel_vld && !trap_fault && !irq_ack);

    // R6
    flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sq_vld |=> !sq_vld);

    // R7
    irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> !hd_vld[0] && !st_pend);

    // R8
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_cnt != '0 |=> arch_npc == $past(arch_npc) + (PC_W'($past(cmt_cnt)) << 2)
                          && arch_pc == arch_npc - PC_W'(4));

    // R8
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_cnt == '0 |=> $stable(arch_pc) && $stable(arch_npc));

    // R9
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_vld |-> cmt_cnt != '0);
endmodule

bind rob_commit_ctrl rob_commit_ctrl_chk #(.COMMIT_W(COMMIT_W), .PC_W(PC_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hd_vld     (hd_vld),
    .st_pend    (st_pend),
    .pop_cnt    (pop_cnt),
    .cmt_cnt    (cmt_cnt),
    .done_vld   (done_vld),
    .rel_vld    (rel_vld),
    .trap_fault (trap_fault),
    .irq_ack    (irq_ack),
    .sq_vld     (sq_vld),
    .arch_pc    (arch_pc),
    .arch_npc   (arch_npc)
);

// File: tb/rob_commit_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: table of window patterns, then directed trap, interrupt and reset tests.
module rob_commit_ctrl_tb_top;
    localparam int          W     = 4;
    localparam int          SW    = 16;
    localparam int          PW    = 32;
    localparam int          DW    = 4;
    localparam logic [31:0] RPC   = 32'h0000_1000;
    localparam logic [15:0] BASE  = 16'h0040;

    typedef struct packed {
        logic [3:0] vld, rdy, exe, sqd, flt, ser;
        logic       st;
        logic [2:0] cmt, pop;
        logic       rel;
        logic [1:0] idx;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{4'hF, 4'hF, 4'hF, 4'h0, 4'h0, 4'h0, 1'b0, 3'd4, 3'd4, 1'b0, 2'd3},
        '{4'h3, 4'hF, 4'hF, 4'h0, 4'h0, 4'h0, 1'b0, 3'd2, 3'd2, 1'b0, 2'd1},
        '{4'hF, 4'hD, 4'hF, 4'h0, 4'h0, 4'h0, 1'b0, 3'd1, 3'd1, 1'b0, 2'd0},
        '{4'hF, 4'hF, 4'hF, 4'h1, 4'h0, 4'h0, 1'b0, 3'd3, 3'd4, 1'b0, 2'd3},
        '{4'hF, 4'h0, 4'h0, 4'hF, 4'h0, 4'h0, 1'b0, 3'd0, 3'd4, 1'b0, 2'd0},
        '{4'hF, 4'hF, 4'hE, 4'h0, 4'h0, 4'h1, 1'b0, 3'd0, 3'd0, 1'b1, 2'd0},
        '{4'hF, 4'hF, 4'hE, 4'h0, 4'h0, 4'h1, 1'b1, 3'd0, 3'd0, 1'b0, 2'd0},
        '{4'hF, 4'hF, 4'hB, 4'h0, 4'h0, 4'h4, 1'b0, 3'd2, 3'd2, 1'b0, 2'd1},
        '{4'hF, 4'hF, 4'hD, 4'h1, 4'h0, 4'h2, 1'b0, 3'd0, 3'd1, 1'b1, 2'd1},
        '{4'hF, 4'hF, 4'hF, 4'h0, 4'h2, 4'h0, 1'b0, 3'd1, 3'd1, 1'b0, 2'd0},
        '{4'hF, 4'hF, 4'hF, 4'h0, 4'h1, 4'h0, 1'b1, 3'd0, 3'd0, 1'b0, 2'd0},
        '{4'hF, 4'hF, 4'hD, 4'h0, 4'h0, 4'h0, 1'b0, 3'd1, 3'd1, 1'b0, 2'd0}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [W-1:0]    hd_vld = '0, hd_rdy = '0, hd_exe = '0, hd_sqd = '0, hd_flt = '0, hd_ser = '0;
    logic [W*SW-1:0] hd_seq;
    logic            st_pend = 1'b0, irq_req = 1'b0;
    logic [DW-1:0]   trap_dly = '0;
    logic [2:0]      pop_cnt, cmt_cnt;
    logic            done_vld, rel_vld, trap_fault, irq_ack, sq_vld;
    logic [SW-1:0]   done_seq, rel_seq, sq_seq;
    logic [PW-1:0]   arch_pc, arch_npc;

    int n_cmp = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    for (genvar g = 0; g < W; g++) begin : g_seq
        assign hd_seq[g*SW +: SW] = BASE + SW'(g);
    end

    rob_commit_ctrl #(.COMMIT_W(W), .SEQ_W(SW), .PC_W(PW), .DLY_W(DW), .RESET_PC(RPC)) dut_i (
        .clk(clk), .rst_n(rst_n), .hd_vld(hd_vld), .hd_rdy(hd_rdy), .hd_exe(hd_exe),
        .hd_sqd(hd_sqd), .hd_flt(hd_flt), .hd_ser(hd_ser), .hd_seq(hd_seq),
        .st_pend(st_pend), .irq_req(irq_req), .trap_dly(trap_dly),
        .pop_cnt(pop_cnt), .cmt_cnt(cmt_cnt), .done_vld(done_vld), .done_seq(done_seq),
        .rel_vld(rel_vld), .rel_seq(rel_seq), .trap_fault(trap_fault), .irq_ack(irq_ack),
        .sq_vld(sq_vld), .sq_seq(sq_seq), .arch_pc(arch_pc), .arch_npc(arch_npc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic win(input logic [3:0] v, r, e, s, f, z, input logic st);
        hd_vld = v; hd_rdy = r; hd_exe = e; hd_sqd = s; hd_flt = f; hd_ser = z; st_pend = st;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        logic [31:0] exp_npc;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8 reset state
        chk("R8 reset pc", arch_pc, RPC);
        chk("R8 reset npc", arch_npc, RPC + 4);
        chk("R5 reset no flush", {31'd0, sq_vld}, 0);
        chk("R1 reset empty cmt", {29'd0, cmt_cnt}, 0);
        exp_npc = RPC + 4;

        // Table walk: R1 R2 R3 R4 R9
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            win(TBL[i].vld, TBL[i].rdy, TBL[i].exe, TBL[i].sqd, TBL[i].flt, TBL[i].ser, TBL[i].st);
            #1;
            chk($sformatf("R1 vec%0d cmt", i), {29'd0, cmt_cnt}, {29'd0, TBL[i].cmt});
            chk($sformatf("R2 vec%0d pop", i), {29'd0, pop_cnt}, {29'd0, TBL[i].pop});
            chk($sformatf("R3 vec%0d rel", i), {31'd0, rel_vld}, {31'd0, TBL[i].rel});
            chk($sformatf("R4 vec%0d no trap", i), {31'd0, trap_fault}, 0);
            chk($sformatf("R9 vec%0d done_vld", i), {31'd0, done_vld}, {31'd0, TBL[i].cmt != 0});
            if (TBL[i].cmt != 0)
                chk($sformatf("R9 vec%0d done_seq", i), {16'd0, done_seq}, {16'd0, BASE + 16'(TBL[i].idx)});
            if (TBL[i].rel)
                chk($sformatf("R3 vec%0d rel_seq", i), {16'd0, rel_seq}, {16'd0, BASE + 16'(TBL[i].idx)});
            exp_npc = exp_npc + 32'(TBL[i].cmt) * 4;
        end
        @(negedge clk);
        win(4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0);
        #1;
        chk("R8 npc after table", arch_npc, exp_npc);
        chk("R8 pc after table", arch_pc, exp_npc - 4);

        // R4 R5 R6: fault trap at the head with delay 3
        @(negedge clk);
        trap_dly = 4'd3;
        win(4'hF, 4'hF, 4'hF, 4'h0, 4'h1, 4'h0, 1'b0);
        #1;
        chk("R4 fault trap taken", {31'd0, trap_fault}, 1);
        chk("R4 fault no pop", {29'd0, pop_cnt}, 0);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            win(4'hF, 4'hF, 4'hF, 4'h0, 4'h0, 4'h0, 1'b0);
            #1;
            chk($sformatf("R5 pending cmt k%0d", k), {29'd0, cmt_cnt}, 0);
            chk($sformatf("R5 pending pop k%0d", k), {29'd0, pop_cnt}, 0);
            chk($sformatf("R5 flush timing k%0d", k), {31'd0, sq_vld}, {31'd0, k == 4});
        end
        chk("R5 flush seq", {16'd0, sq_seq}, {16'd0, BASE - 16'd1});
        @(negedge clk);
        #1;
        chk("R6 resumed cmt", {29'd0, cmt_cnt}, 4);
        chk("R6 flush dropped", {31'd0, sq_vld}, 0);

        // R7: interrupt waits for stores, then is taken with delay 0
        @(negedge clk);
        trap_dly = 4'd0;
        irq_req = 1'b1;
        win(4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1);
        #1;
        chk("R7 irq blocked by stores", {31'd0, irq_ack}, 0);
        @(negedge clk);
        st_pend = 1'b0;
        #1;
        chk("R7 irq accepted", {31'd0, irq_ack}, 1);
        @(negedge clk);
        #1;
        chk("R7 irq flush", {31'd0, sq_vld}, 1);
        chk("R7 irq flush seq", {16'd0, sq_seq}, 0);
        chk("R5 irq pending no ack", {31'd0, irq_ack}, 0);
        @(negedge clk);
        win(4'hF, 4'hF, 4'hF, 4'h0, 4'h0, 4'h0, 1'b0);
        #1;
        chk("R7 irq blocked by busy buffer", {31'd0, irq_ack}, 0);
        chk("R1 commit beside irq", {29'd0, cmt_cnt}, 4);
        @(negedge clk);
        irq_req = 1'b0;
        win(4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0);

        // R3: serialising entry behind a retired one is not released
        @(negedge clk);
        win(4'hF, 4'hF, 4'hD, 4'h0, 4'h0, 4'h2, 1'b0);
        #1;
        chk("R3 no release after retire", {31'd0, rel_vld}, 0);
        chk("R3 retire before serial", {29'd0, cmt_cnt}, 1);
        @(negedge clk);
        win(4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0);

        repeat (2) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule